// File: doc/BRIEF.md
# Linear Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address by looking up one entry of a flat, single-level page table stored in memory. A request carries the virtual address and an access kind: read, write or execute. The page table's base byte address and its length in entries come in as two register inputs, which must stay stable while a walk is in progress.

The walker checks the page number against the table length before it touches memory. It then fetches one 32-bit entry over a request/acknowledge memory port whose latency can be any number of cycles. It tests the entry's valid bit, and then the permission bit for the requested kind. On success it sets the entry's referenced bit, and also the dirty bit for a write. It stores the entry back only when one of those bits changes. When the walk is finished it returns either the physical address or a fault code.

Page size is 4096 bytes. The physical address is the entry's 18-bit frame number placed above the untouched 12-bit offset.

Top module: `pt_walker`

## Requirements
- R1: On success the response carries physical address = {entry bits [17:0], virtual address bits [11:0]}, with fault code 0.
- R2: For a page number p inside the table, exactly one entry read is issued, at byte address base + 4*p.
- R3: A page number that is not below the table length register gives fault code 1. It causes no memory read and no memory write.
- R4: A fetched entry whose bit 18 (valid) is 0 gives fault code 2, and the entry is not written.
- R5: The access kind code selects the permission bit: 0 (read) uses bit 23, 1 (write) uses bit 22, and 2 or 3 (execute) use bit 21. If that bit is clear the result is fault code 3 and the entry is not written.
- R6: When several checks would fail, the code comes from the first failing one in the order bounds, valid, permission. Every faulting response carries a physical address of 0.
- R7: On success the entry gets bit 19 (referenced) set, and on a write also bit 20 (dirty). Frame, protection and reserved bits [31:24] stay as they were. The entry is written back once, before the response, and only if its value changed.
- R8: req_ready is high only while idle. A request is taken on a clock edge where req_valid and req_ready are both high. rsp_valid is a one-cycle pulse, and the walker is idle again in the following cycle.
- R9: mem_req stays high, with mem_addr, mem_we and mem_wdata unchanged, until the cycle in which mem_ack is high.
- R10: During reset and right after it, req_ready is 1 and mem_req and rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| pt_base | input | 30 | Byte address of the page table |
| pt_size | input | 21 | Number of entries in the page table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_addr | output | 30 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Memory access complete (one-cycle pulse) |
| mem_rdata | input | 32 | Entry read data, valid with mem_ack |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 30 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 bounds, 2 invalid, 3 protection |

## Verification
In the cycle where the read acknowledge arrives, the walker sorts the entry into a fault class and also decides whether a write-back is needed. Both decisions are taken from the same returned word. To exercise this, the bench sweeps every page number of a small table, in bounds and out of bounds, under all four kind codes. Each entry has a known protection pattern and a preset referenced and dirty state. The whole sweep then runs a second time, after the first pass has set those bits. Each response is checked against a fault code and address computed from the bench's own copy of the table. The bench also checks how many reads and writes the memory model served, and what the stored entry holds afterwards.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_EXEC2 = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_BOUNDS  = 2'd1,
      FLT_INVALID = 2'd2,
      FLT_PROT    = 2'd3
   } fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RANGE,
      ST_FETCH,
      ST_STORE,
      ST_DONE
   } walk_state_e;

endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
   parameter int PN_W = 20,
   parameter int PA_W = 30
) (
   input  logic [PN_W-1:0] vpn,
   input  logic [PA_W-1:0] base,
   input  logic [PN_W:0]   limit,
   output logic [PA_W-1:0] pte_addr,
   output logic            in_bounds
);
   localparam int SCALE_W = PN_W + 2;

   logic [PA_W-1:0] scaled;

   always_comb begin
      scaled = '0;
      scaled[SCALE_W-1:0] = {vpn, 2'b00};
   end

   assign pte_addr  = base + scaled;
   assign in_bounds = ({1'b0, vpn} < limit);

endmodule

// File: rtl/pgw_pte_check.sv
module pgw_pte_check
   import pgw_pkg::*;
#(
   parameter int FRAME_W = 18,
   parameter int PTE_W   = 32,
   parameter bit WB_EN   = 1'b1
) (
   input  logic [PTE_W-1:0]   pte,
   input  acc_kind_e          kind,
   output fault_e             fault,
   output logic [FRAME_W-1:0] frame,
   output logic [PTE_W-1:0]   pte_new,
   output logic               wb_need
);
   localparam int B_VALID = FRAME_W;
   localparam int B_REF   = FRAME_W + 1;
   localparam int B_DIRTY = FRAME_W + 2;
   localparam int B_EXEC  = FRAME_W + 3;
   localparam int B_WRITE = FRAME_W + 4;
   localparam int B_READ  = FRAME_W + 5;

   logic perm_ok;

   always_comb begin
      unique case (kind)
         ACC_READ:  perm_ok = pte[B_READ];
         ACC_WRITE: perm_ok = pte[B_WRITE];
         default:   perm_ok = pte[B_EXEC];
      endcase
   end

   always_comb begin
      if (!pte[B_VALID])  fault = FLT_INVALID;
      else if (!perm_ok)  fault = FLT_PROT;
      else                fault = FLT_NONE;
   end

   assign frame = pte[FRAME_W-1:0];

   generate
      if (WB_EN) begin : g_track
         always_comb begin
            pte_new = pte;
            pte_new[B_REF] = 1'b1;
            if (kind == ACC_WRITE) pte_new[B_DIRTY] = 1'b1;
         end
         assign wb_need = (fault == FLT_NONE) && (pte_new != pte);
      end else begin : g_notrack
         assign pte_new = pte;
         assign wb_need = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pgw_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int OFF_W = 12,
   parameter int PA_W  = 30,
   parameter int PTE_W = 32,
   parameter bit WB_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic [1:0]         req_kind,
   input  logic [PA_W-1:0]    pt_base,
   input  logic [VA_W-OFF_W:0] pt_size,
   output logic               mem_req,
   output logic               mem_we,
   output logic [PA_W-1:0]    mem_addr,
   output logic [PTE_W-1:0]   mem_wdata,
   input  logic               mem_ack,
   input  logic [PTE_W-1:0]   mem_rdata,
   output logic               rsp_valid,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [1:0]         rsp_fault
);
   localparam int PN_W    = VA_W - OFF_W;
   localparam int FRAME_W = PA_W - OFF_W;

   generate
      if (PA_W <= OFF_W) begin : g_bad_pa
         $error("physical width must exceed offset width");
      end
      if (PTE_W < FRAME_W + 6) begin : g_bad_pte
         $error("entry too narrow for frame and flag fields");
      end
      if (PA_W < PN_W + 2) begin : g_bad_span
         $error("physical width cannot span the largest table");
      end
   endgenerate

   walk_state_e        state;
   logic [VA_W-1:0]    vaddr_q;
   acc_kind_e          kind_q;
   logic [PTE_W-1:0]   pte_q;
   logic [PA_W-1:0]    paddr_q;
   fault_e             fault_q;

   logic [PA_W-1:0]    pte_addr;
   logic               in_bounds;
   fault_e             chk_fault;
   logic [FRAME_W-1:0] chk_frame;
   logic [PTE_W-1:0]   chk_pte_new;
   logic               chk_wb;

   pgw_addr_gen #(.PN_W(PN_W), .PA_W(PA_W)) u_addr (
      .vpn       (vaddr_q[VA_W-1:OFF_W]),
      .base      (pt_base),
      .limit     (pt_size),
      .pte_addr  (pte_addr),
      .in_bounds (in_bounds)
   );

   pgw_pte_check #(.FRAME_W(FRAME_W), .PTE_W(PTE_W), .WB_EN(WB_EN)) u_chk (
      .pte     (mem_rdata),
      .kind    (kind_q),
      .fault   (chk_fault),
      .frame   (chk_frame),
      .pte_new (chk_pte_new),
      .wb_need (chk_wb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         vaddr_q <= '0;
         kind_q  <= ACC_READ;
         pte_q   <= '0;
         paddr_q <= '0;
         fault_q <= FLT_NONE;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  vaddr_q <= req_vaddr;
                  kind_q  <= acc_kind_e'(req_kind);
                  state   <= ST_RANGE;
               end
            end
            ST_RANGE: begin
               if (in_bounds) begin
                  state <= ST_FETCH;
               end else begin
                  fault_q <= FLT_BOUNDS;
                  paddr_q <= '0;
                  state   <= ST_DONE;
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  fault_q <= chk_fault;
                  paddr_q <= (chk_fault == FLT_NONE) ?
                             {chk_frame, vaddr_q[OFF_W-1:0]} : '0;
                  pte_q   <= chk_pte_new;
                  state   <= chk_wb ? ST_STORE : ST_DONE;
               end
            end
            ST_STORE: begin
               if (mem_ack) state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign mem_req   = (state == ST_FETCH) || (state == ST_STORE);
   assign mem_we    = (state == ST_STORE);
   assign mem_addr  = pte_addr;
   assign mem_wdata = pte_q;
   assign rsp_valid = (state == ST_DONE);
   assign rsp_paddr = paddr_q;
   assign rsp_fault = fault_q;

   // R9: memory request held steady until acknowledged
   assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

   // R8: an idle walker drives no memory access and no response
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req && !rsp_valid));

   // R8: response is a single-cycle pulse followed by idle
   assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   // R6: faulting responses carry a zero address
   assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

   // R7: a written-back entry is valid and marked referenced
   assert_wb_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[FRAME_W] && mem_wdata[FRAME_W+1]));

   // R3: an out-of-range page never reaches the memory port
   assert_bounds_nomem_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RANGE && !in_bounds) |=> !mem_req);

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
   import pgw_pkg::*;

   localparam int          LAT  = 3;
   localparam int          NENT = 16;
   localparam logic [29:0] BASE = 30'h0001_2340;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_vaddr;
   logic [1:0]  req_kind;
   logic [29:0] pt_base;
   logic [20:0] pt_size;
   logic        mem_req;
   logic        mem_we;
   logic [29:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack;
   logic [31:0] mem_rdata;
   logic        rsp_valid;
   logic [29:0] rsp_paddr;
   logic [1:0]  rsp_fault;

   always #10 clk = ~clk;

   pt_walker u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_kind(req_kind),
      .pt_base(pt_base), .pt_size(pt_size),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
   );

   function automatic logic [31:0] init_pte(input int i);
      logic [31:0] e;
      e = '0;
      e[17:0]  = 18'h25C00 ^ 18'(i * 273);
      e[18]    = !(i == 10 || i == 11);
      e[19]    = (i >= 8);
      e[20]    = (i >= 12);
      e[23:21] = 3'(i);
      e[31:24] = 8'(i * 17 + 3);
      return e;
   endfunction

   logic [31:0] tbl [NENT];
   int          n_rd;
   int          n_wr;
   int          lat_cnt;
   logic [29:0] last_rd_addr;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NENT; i++) tbl[i] <= init_pte(i);
         mem_ack <= 1'b0; mem_rdata <= '0; lat_cnt <= 0;
         n_rd <= 0; n_wr <= 0; last_rd_addr <= '0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0; lat_cnt <= 0;
      end else if (mem_req) begin
         if (lat_cnt == LAT - 1) begin
            automatic int idx = int'((mem_addr - BASE) >> 2);
            mem_ack <= 1'b1; lat_cnt <= 0;
            if (mem_we) begin
               if (idx >= 0 && idx < NENT) tbl[idx] <= mem_wdata;
               n_wr <= n_wr + 1;
            end else begin
               mem_rdata    <= (idx >= 0 && idx < NENT) ? tbl[idx] : 32'hDEAD_BEEF;
               n_rd         <= n_rd + 1;
               last_rd_addr <= mem_addr;
            end
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   int          errors = 0;
   int          checks = 0;
   logic [31:0] shadow [NENT];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input int v, input int kind, input logic [20:0] size);
      logic [11:0] off;
      logic [31:0] old, nw;
      logic [1:0]  e_flt;
      logic [29:0] e_pa;
      bit          perm, e_wr, inb, got, ready_checked;
      int          rd0, wr0;
      off = 12'((v * 373 + kind * 91 + 5) & 32'hFFF);
      inb = (v < int'(size));
      old = shadow[v];
      nw  = old;
      e_wr = 1'b0;
      e_pa = '0;
      if (!inb) e_flt = 2'd1;
      else if (!old[18]) e_flt = 2'd2;
      else begin
         perm = (kind == 0) ? old[23] : (kind == 1) ? old[22] : old[21];
         if (!perm) e_flt = 2'd3;
         else begin
            e_flt = 2'd0;
            e_pa  = {old[17:0], off};
            nw[19] = 1'b1;
            if (kind == 1) nw[20] = 1'b1;
            e_wr = (nw != old);
         end
      end
      rd0 = n_rd; wr0 = n_wr;
      @(negedge clk);
      pt_size   = size;
      req_valid = 1'b1;
      req_vaddr = {20'(v), off};
      req_kind  = 2'(kind);
      @(negedge clk);
      req_valid = 1'b0;
      got = 1'b0; ready_checked = 1'b0;
      for (int c = 0; c < 100 && !got; c++) begin
         if (mem_req && !ready_checked) begin
            chk(req_ready == 1'b0, "R8 ready low while busy", 32'(req_ready), 32'd0);
            ready_checked = 1'b1;
         end
         if (rsp_valid) got = 1'b1;
         else @(negedge clk);
      end
      chk(got, "R8 response arrives", 32'(got), 32'd1);
      // R3 R4 R5 R6: fault code and priority
      chk(rsp_fault == e_flt, "R6 fault code", 32'(rsp_fault), 32'(e_flt));
      // R1: physical address
      chk(rsp_paddr == e_pa, "R1 physical address", 32'(rsp_paddr), 32'(e_pa));
      // R2 R3: read count and address
      chk((n_rd - rd0) == (inb ? 1 : 0), "R3 read count", 32'(n_rd - rd0),
          32'(inb ? 1 : 0));
      if (inb)
         chk(last_rd_addr == BASE + 30'(4 * v), "R2 entry address",
             32'(last_rd_addr), 32'(BASE + 30'(4 * v)));
      // R7: write-back count and stored entry
      chk((n_wr - wr0) == (e_wr ? 1 : 0), "R7 write count", 32'(n_wr - wr0),
          32'(e_wr ? 1 : 0));
      chk(tbl[v] == nw, "R7 stored entry", tbl[v], nw);
      shadow[v] = nw;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
      pt_base = BASE; pt_size = 21'd12;
      for (int i = 0; i < NENT; i++) shadow[i] = init_pte(i);
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(req_ready == 1'b1, "R10 ready in reset", 32'(req_ready), 32'd1);
      chk(mem_req == 1'b0, "R10 no mem req", 32'(mem_req), 32'd0);
      chk(rsp_valid == 1'b0, "R10 no response", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'd1);
      // sweep twice: first pass sets referenced/dirty, second finds them set
      for (int pass = 0; pass < 2; pass++)
         for (int v = 0; v < NENT; v++)
            for (int k = 0; k < 4; k++)
               run(v, k, 21'd12);
      // boundaries of the table length register
      run(0, 0, 21'd0);
      run(11, 1, 21'd11);
      run(10, 0, 21'd11);
      run(15, 1, 21'd16);
      run(13, 2, 21'd16);
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule